// File: doc/BRIEF.md
# Metered Floating-Point Unit Enable Controller

This block decides whether an on-chip floating-point unit may run. It holds a preloaded table of one-byte unlock codes. It takes code-entry attempts on a valid/data input. Each correct code adds a fixed budget of floating-point operations to a credit counter. A one-cycle operation-done pulse from the unit spends one operation of that budget. The enable output is high while budget remains.

Codes must be redeemed in table order. A run of wrong codes locks the unit for good. Redeeming the final table entry enables it for good, whatever the credit.

A control FSM has three named states:
- **ST_METERED**: enable follows the credit.
- **ST_LOCKED**: the unit is disabled forever and attempts are ignored.
- **ST_UNLIMITED**: the unit is enabled forever and attempts are ignored.

The FSM has three named transitions:
- **LOCKOUT** (ST_METERED to ST_LOCKED): a miss that brings the consecutive-failure count to FAIL_LIMIT.
- **PAYOFF** (ST_METERED to ST_UNLIMITED): a hit on entry NUM_CODES-1.
- **WIPE** (any state to ST_METERED): factory clear.

The ordinary reset models a power cycle. It clears the index, credit and failure count. It leaves the state register alone, because that state stands for non-volatile storage.

Top module: `fpu_meter_ctrl`

## Requirements
- R1: Factory clear (`fclr_i`, synchronous) puts the block in ST_METERED with index, credit and failure count at zero. After it, `fpu_en_o`, `locked_o`, `unlimited_o`, `accept_o` and `reject_o` are all 0.
- R2: Table entry i holds (37*i + SEED) mod 256. An attempt in ST_METERED is compared only with the entry at the current redemption index. A match is a hit and advances the index by one. Any other value, including another entry's code, is a miss.
- R3: Each hit adds GRANT operations of credit. In ST_METERED `fpu_en_o` is 1 exactly when the credit is nonzero. Each `op_done_i` cycle lowers a nonzero credit by one. At zero credit, `op_done_i` has no effect, so the credit does not wrap.
- R4: Credit saturates at 2^CREDIT_W-1 when a hit would push it past that value.
- R5: A hit clears the consecutive-failure count.
- R6: The miss that brings the consecutive-failure count to FAIL_LIMIT moves the FSM to ST_LOCKED. In ST_LOCKED, `locked_o`=1 and `fpu_en_o`=0 even with credit left.
- R7: Attempts in ST_LOCKED or ST_UNLIMITED produce no response pulse and change no state, even when the code is correct.
- R8: A hit on entry NUM_CODES-1 moves the FSM to ST_UNLIMITED. There `unlimited_o`=1 and `fpu_en_o`=1 regardless of credit and `op_done_i`.
- R9: `rst_i` clears the index, credit and failure count. It keeps ST_LOCKED and ST_UNLIMITED.
- R10: Every attempt in ST_METERED gives exactly one pulse. The pulse is on `accept_o` for a hit or on `reject_o` for a miss. It is high for the single cycle after the attempt's clock edge, and the two pulses are never high together.
- R11: Factory clear leaves ST_LOCKED and ST_UNLIMITED and returns to ST_METERED.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous power-cycle reset (keeps sticky state) |
| fclr_i | input | 1 | Synchronous factory clear (clears everything) |
| try_valid_i | input | 1 | Code-entry attempt strobe |
| try_code_i | input | CODE_W | Code value offered |
| op_done_i | input | 1 | One floating-point operation finished |
| fpu_en_o | output | 1 | Floating-point unit enable |
| locked_o | output | 1 | Permanent lockout flag |
| unlimited_o | output | 1 | Permanent enable flag |
| accept_o | output | 1 | Hit response pulse |
| reject_o | output | 1 | Miss response pulse |

## Verification
The response pulses are registered. They are due in the cycle after the clock edge that samples the attempt, and they must be gone one cycle later. The bench drives inputs on falling edges and reads `accept_o`/`reject_o` at the next falling edge and the one after.

Credit, index, failure count and FSM state also update on the edge that samples the input. `fpu_en_o`, `locked_o` and `unlimited_o` are combinational from those registers, so they are checked at the same falling edge as the pulse.

Credit has no port of its own. It is measured by counting operation-done pulses until `fpu_en_o` drops. The check looks one operation before the expected drop and again exactly at it.

// File: rtl/fpu_meter_pkg.sv
package fpu_meter_pkg;

    typedef enum logic [1:0] {
        ST_METERED   = 2'd0,
        ST_LOCKED    = 2'd1,
        ST_UNLIMITED = 2'd2
    } meter_state_e;

    // Per-device code for table entry idx; 37 is odd, so entries are distinct mod 256.
    function automatic logic [7:0] entry_code(input logic [7:0] seed, input int idx);
        int v;
        v = (idx * 37 + int'(seed)) % 256;
        return 8'(v);
    endfunction

endpackage

// File: rtl/fpu_meter_rom.sv
module fpu_meter_rom #(
    parameter int         NUM_CODES = 100,
    parameter int         CODE_W    = 8,
    parameter logic [7:0] SEED      = 8'h5A,
    localparam int        IDX_W     = $clog2(NUM_CODES + 1)
) (
    input  logic [IDX_W-1:0]  idx_i,
    output logic [CODE_W-1:0] code_o
);
    logic [CODE_W-1:0] table_q [NUM_CODES];

    for (genvar g = 0; g < NUM_CODES; g++) begin : g_entry
        assign table_q[g] = CODE_W'(fpu_meter_pkg::entry_code(SEED, g));
    end

    always_comb begin
        code_o = '0;
        for (int i = 0; i < NUM_CODES; i++) begin
            if (idx_i == IDX_W'(i)) code_o = table_q[i];
        end
    end
endmodule

// File: rtl/fpu_meter_credit.sv
module fpu_meter_credit #(
    parameter int          CREDIT_W = 34,
    parameter logic [63:0] GRANT    = 64'd10_000_000_000
) (
    input  logic clk_i,
    input  logic clr_i,
    input  logic add_i,
    input  logic take_i,
    output logic nonzero_o
);
    localparam logic [63:0] CMAX = (64'd1 << CREDIT_W) - 64'd1;

    logic [CREDIT_W-1:0] credit_q;
    logic [63:0]         sum;
    logic                dec;

    assign nonzero_o = (credit_q != '0);
    assign dec       = take_i && nonzero_o;

    always_comb begin
        sum = 64'(credit_q);
        if (add_i) sum = sum + GRANT;
        if (dec)   sum = sum - 64'd1;
        if (sum > CMAX) sum = CMAX;
    end

    always_ff @(posedge clk_i) begin
        if (clr_i) credit_q <= '0;
        else       credit_q <= sum[CREDIT_W-1:0];
    end
endmodule

// File: rtl/fpu_meter_ctrl.sv
module fpu_meter_ctrl #(
    parameter int          NUM_CODES  = 100,
    parameter int          CODE_W     = 8,
    parameter int          CREDIT_W   = 34,
    parameter logic [63:0] GRANT      = 64'd10_000_000_000,
    parameter int          FAIL_LIMIT = 3,
    parameter logic [7:0]  SEED       = 8'h5A
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              fclr_i,
    input  logic              try_valid_i,
    input  logic [CODE_W-1:0] try_code_i,
    input  logic              op_done_i,
    output logic              fpu_en_o,
    output logic              locked_o,
    output logic              unlimited_o,
    output logic              accept_o,
    output logic              reject_o
);
    import fpu_meter_pkg::*;

    localparam int IDX_W  = $clog2(NUM_CODES + 1);
    localparam int FAIL_W = $clog2(FAIL_LIMIT + 1);

    meter_state_e      state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic [FAIL_W-1:0] fails_q;
    logic [CODE_W-1:0] expect_code;
    logic              live, hit, miss, credit_nz;

    fpu_meter_rom #(
        .NUM_CODES(NUM_CODES), .CODE_W(CODE_W), .SEED(SEED)
    ) u_rom (
        .idx_i (idx_q),
        .code_o(expect_code)
    );

    fpu_meter_credit #(
        .CREDIT_W(CREDIT_W), .GRANT(GRANT)
    ) u_credit (
        .clk_i    (clk_i),
        .clr_i    (rst_i || fclr_i),
        .add_i    (hit),
        .take_i   (op_done_i && (state_q != ST_UNLIMITED)),
        .nonzero_o(credit_nz)
    );

    assign live = try_valid_i && (state_q == ST_METERED);
    assign hit  = live && (try_code_i == expect_code);
    assign miss = live && (try_code_i != expect_code);

    // Next-state logic: LOCKOUT and PAYOFF transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_METERED: begin
                if (hit && (idx_q == IDX_W'(NUM_CODES - 1)))
                    state_d = ST_UNLIMITED;
                else if (miss && (fails_q == FAIL_W'(FAIL_LIMIT - 1)))
                    state_d = ST_LOCKED;
            end
            ST_LOCKED:    state_d = ST_LOCKED;
            ST_UNLIMITED: state_d = ST_UNLIMITED;
            default:      state_d = ST_METERED;
        endcase
    end

    // State register: only factory clear (WIPE) leaves the sticky states
    always_ff @(posedge clk_i) begin
        if (fclr_i) state_q <= ST_METERED;
        else        state_q <= state_d;
    end

    // Volatile counters and response pulses
    always_ff @(posedge clk_i) begin
        if (rst_i || fclr_i) begin
            idx_q    <= '0;
            fails_q  <= '0;
            accept_o <= 1'b0;
            reject_o <= 1'b0;
        end else begin
            accept_o <= hit;
            reject_o <= miss;
            if (hit) begin
                idx_q   <= idx_q + IDX_W'(1);
                fails_q <= '0;
            end else if (miss) begin
                fails_q <= fails_q + FAIL_W'(1);
            end
        end
    end

    // Output decode
    always_comb begin
        fpu_en_o    = 1'b0;
        locked_o    = 1'b0;
        unlimited_o = 1'b0;
        unique case (state_q)
            ST_METERED:   fpu_en_o = credit_nz;
            ST_LOCKED:    locked_o = 1'b1;
            ST_UNLIMITED: begin
                fpu_en_o    = 1'b1;
                unlimited_o = 1'b1;
            end
            default:      fpu_en_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/fpu_meter_ctrl_chk.sv
module fpu_meter_ctrl_chk (
    input logic clk_i,
    input logic rst_i,
    input logic fclr_i,
    input logic try_valid_i,
    input logic fpu_en_o,
    input logic locked_o,
    input logic unlimited_o,
    input logic accept_o,
    input logic reject_o
);
    // R6
    lock_sticky_chk: assert property (@(posedge clk_i) disable iff (fclr_i)
        locked_o |=> locked_o);
    // R8
    unlim_sticky_chk: assert property (@(posedge clk_i) disable iff (fclr_i)
        unlimited_o |=> unlimited_o);
    // R6
    lock_disables_chk: assert property (@(posedge clk_i) disable iff (fclr_i)
        locked_o |-> !fpu_en_o);
    // R8
    unlim_enables_chk: assert property (@(posedge clk_i) disable iff (fclr_i)
        unlimited_o |-> (fpu_en_o && !locked_o));
    // R7
    ignored_try_chk: assert property (@(posedge clk_i) disable iff (rst_i || fclr_i)
        ((locked_o || unlimited_o) && try_valid_i) |=> !(accept_o || reject_o));
    // R10
    one_response_chk: assert property (@(posedge clk_i) disable iff (rst_i || fclr_i)
        $countones({accept_o, reject_o}) <= 1);
    // R10
    response_has_try_chk: assert property (@(posedge clk_i) disable iff (rst_i || fclr_i)
        !try_valid_i |=> !(accept_o || reject_o));
endmodule

bind fpu_meter_ctrl fpu_meter_ctrl_chk u_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .fclr_i     (fclr_i),
    .try_valid_i(try_valid_i),
    .fpu_en_o   (fpu_en_o),
    .locked_o   (locked_o),
    .unlimited_o(unlimited_o),
    .accept_o   (accept_o),
    .reject_o   (reject_o)
);

// File: tb/fpu_meter_ctrl_tb.sv
module fpu_meter_ctrl_tb;
    localparam int         NUM_CODES = 100;
    localparam int         CREDIT_W  = 4;
    localparam int         GRANT     = 5;
    localparam logic [7:0] SEED      = 8'h5A;

    logic clk = 1'b0, rst = 1'b1, fclr = 1'b1;
    logic tv = 1'b0, op = 1'b0;
    logic [7:0] tc = '0;
    logic en, lk, ul, acc, rej;
    int checks = 0, fails = 0;

    always #2.5 clk = ~clk;

    fpu_meter_ctrl #(
        .NUM_CODES(NUM_CODES), .CODE_W(8), .CREDIT_W(CREDIT_W),
        .GRANT(64'(GRANT)), .FAIL_LIMIT(3), .SEED(SEED)
    ) u_dut (
        .clk_i(clk), .rst_i(rst), .fclr_i(fclr), .try_valid_i(tv),
        .try_code_i(tc), .op_done_i(op), .fpu_en_o(en), .locked_o(lk),
        .unlimited_o(ul), .accept_o(acc), .reject_o(rej)
    );

    function automatic logic [7:0] code(input int i);
        return 8'((i * 37 + int'(SEED)) % 256);
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    // attempt, then check response pulse and its removal (R10)
    task automatic attempt(input logic [7:0] c, input logic exp_acc, input logic exp_rej,
                           input string req);
        @(negedge clk); tv = 1'b1; tc = c;
        @(negedge clk); tv = 1'b0;
        chk({req, " accept"}, acc, exp_acc);
        chk({req, " reject"}, rej, exp_rej);
        @(negedge clk);
        chk("R10 pulse width acc", acc, 1'b0);
        chk("R10 pulse width rej", rej, 1'b0);
    endtask

    task automatic ops(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); op = 1'b1;
            @(negedge clk); op = 1'b0;
        end
    endtask

    task automatic pulse_rst(input logic factory);
        @(negedge clk); rst = ~factory; fclr = factory;
        @(negedge clk); rst = 1'b0; fclr = 1'b0;
    endtask

    task automatic t_reset;
        @(negedge clk); @(negedge clk); rst = 1'b0; fclr = 1'b0;
        chk("R1 en", en, 1'b0); chk("R1 locked", lk, 1'b0);
        chk("R1 unlimited", ul, 1'b0); chk("R1 acc", acc, 1'b0);
        chk("R1 rej", rej, 1'b0);
    endtask

    task automatic t_credit;
        attempt(code(0), 1'b1, 1'b0, "R2 hit entry0");
        chk("R3 enabled after hit", en, 1'b1);
        attempt(code(5), 1'b0, 1'b1, "R2 other entry is miss");
        ops(GRANT - 1); chk("R3 credit left", en, 1'b1);
        ops(1);         chk("R3 credit spent", en, 1'b0);
        ops(1);         chk("R3 no wrap at zero", en, 1'b0);
        attempt(code(1), 1'b1, 1'b0, "R2 hit entry1");
        ops(GRANT - 1); chk("R3 no wrap one left", en, 1'b1);
        ops(1);         chk("R3 no wrap drained", en, 1'b0);
    endtask

    task automatic t_fail_clear;
        attempt(8'h00 ^ code(2) ^ 8'hFF, 1'b0, 1'b1, "R5 miss a");
        attempt(code(3), 1'b0, 1'b1, "R5 miss b");
        attempt(code(2), 1'b1, 1'b0, "R5 hit clears");
        attempt(code(9), 1'b0, 1'b1, "R5 miss c");
        attempt(code(9), 1'b0, 1'b1, "R5 miss d");
        chk("R5 not locked", lk, 1'b0);
        attempt(code(3), 1'b1, 1'b0, "R5 hit entry3");
    endtask

    task automatic t_saturate;
        attempt(code(4), 1'b1, 1'b0, "R4 hit entry4");
        attempt(code(5), 1'b1, 1'b0, "R4 hit entry5");
        ops(14); chk("R4 saturated holds 15", en, 1'b1);
        ops(1);  chk("R4 saturated drained", en, 1'b0);
    endtask

    task automatic t_reset_lock;
        attempt(code(6), 1'b1, 1'b0, "R9 hit entry6");
        attempt(code(0), 1'b0, 1'b1, "R9 miss a");
        attempt(code(0), 1'b0, 1'b1, "R9 miss b");
        pulse_rst(1'b0);
        chk("R9 credit cleared", en, 1'b0);
        attempt(code(0), 1'b1, 1'b0, "R9 index cleared");
        attempt(code(0), 1'b0, 1'b1, "R9 miss c");
        attempt(code(0), 1'b0, 1'b1, "R9 miss d");
        chk("R9 failures cleared", lk, 1'b0);
        attempt(code(0), 1'b0, 1'b1, "R6 third miss");
        chk("R6 locked", lk, 1'b1);
        chk("R6 disabled with credit", en, 1'b0);
        attempt(code(1), 1'b0, 1'b0, "R7 locked ignores hit");
        pulse_rst(1'b0);
        chk("R9 lock kept", lk, 1'b1);
        pulse_rst(1'b1);
        chk("R11 lock wiped", lk, 1'b0);
        chk("R11 en after wipe", en, 1'b0);
    endtask

    task automatic t_unlimited;
        for (int i = 0; i < NUM_CODES - 1; i++) begin
            @(negedge clk); tv = 1'b1; tc = code(i);
            @(negedge clk); tv = 1'b0;
            if (acc !== 1'b1) chk("R2 table order", acc, 1'b1);
        end
        chk("R8 not yet unlimited", ul, 1'b0);
        attempt(code(NUM_CODES - 1), 1'b1, 1'b0, "R8 last entry");
        chk("R8 unlimited", ul, 1'b1);
        ops(20); chk("R8 enabled past credit", en, 1'b1);
        attempt(code(0), 1'b0, 1'b0, "R7 unlimited ignores");
        pulse_rst(1'b0);
        chk("R9 unlimited kept", ul, 1'b1);
        chk("R8 en after rst", en, 1'b1);
        attempt(8'h00, 1'b0, 1'b0, "R7 ignored miss 1");
        attempt(8'h00, 1'b0, 1'b0, "R7 ignored miss 2");
        attempt(8'h00, 1'b0, 1'b0, "R7 ignored miss 3");
        chk("R7 no lock from unlimited", lk, 1'b0);
        pulse_rst(1'b1);
        chk("R11 unlimited wiped", ul, 1'b0);
        chk("R1 en after wipe", en, 1'b0);
    endtask

    initial begin
        t_reset();
        t_credit();
        t_fail_clear();
        t_saturate();
        t_reset_lock();
        t_unlimited();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #500000;
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule